// File: doc/BRIEF.md
# Stream Request Priority Arbiter

This block decides which of up to eight transfer streams is serviced next. Each stream presents a request line, an enable line and a two-bit software priority. A request only takes part in arbitration while its stream is enabled. Among the live requests, the one with the highest software priority wins. When priorities are equal, the stream with the lowest number wins.

The winner is registered and presented as a one-hot grant vector, a binary index and a valid flag. A grant is held unchanged, whatever the requests do, until the serviced stream signals the end of its indivisible beat or burst on `done_i`. The edge that samples `done_i` drops the grant. The next edge then runs a fresh arbitration. Software is expected to change a stream's priority only while that stream is disabled.

Top module: `stream_prio_arbiter`

## Requirements
- R1: While `rst_n` is low and after its release, `grant_o` is all zeros, `grant_idx_o` is 0 and `valid_o` is low until a live request is arbitrated.
- R2: When no stream is idle-and-live at an arbitration edge, the next outputs are `grant_o`=0, `grant_idx_o`=0, `valid_o`=0; `done_i` while no grant is held has no effect.
- R3: At a clock edge with no grant held, the live stream of highest software priority is granted, and it is visible on the outputs right after that same edge.
- R4: Among live streams that share the top priority, the lowest-numbered stream is granted.
- R5: A request whose enable bit is low is ignored and never granted.
- R6: While a grant is held and `done_i` is low, `grant_o` and `grant_idx_o` stay unchanged, even if requests, enables or priorities change.
- R7: An edge that samples `done_i` high while a grant is held clears the grant, so `valid_o` is low for one cycle. The following edge arbitrates again.
- R8: `grant_o` is zero or one-hot, `valid_o` equals the OR of `grant_o`, and when valid, `grant_o[grant_idx_o]` is set.
- R9: The priority of stream i sits in `prio_i[2i+1:2i]`. The value 0 is lowest and 3 is highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-stream request |
| enable_i | input | 8 | Per-stream enable; masks the request |
| prio_i | input | 16 | Packed 2-bit priorities, stream i at bits 2i+1:2i |
| done_i | input | 1 | End of the granted beat or burst |
| grant_o | output | 8 | One-hot grant |
| grant_idx_o | output | 3 | Index of the granted stream |
| valid_o | output | 1 | A grant is held |

## Verification
Every result arrives one edge after the inputs that cause it. An arbitration decision is visible right after the edge that samples the requests. A release shows up right after the edge that samples `done_i`. A re-arbitration shows up one edge after that.

The bench drives inputs on falling edges. A behavioural model is updated on each rising edge from the same inputs. The model is compared with the outputs on the next falling edge, so each comparison falls exactly one register stage after its stimulus.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int PRIO_W = 2;
    typedef enum logic [PRIO_W-1:0] {
        PL_LOW  = 2'd0,
        PL_MED  = 2'd1,
        PL_HIGH = 2'd2,
        PL_TOP  = 2'd3
    } prio_lvl_e;
endpackage

// File: rtl/arb_mask.sv
module arb_mask #(
    parameter int N  = 8,
    parameter int PW = arb_pkg::PRIO_W
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         en,
    input  logic [N*PW-1:0]      prio_flat,
    output logic [N-1:0]         live,
    output logic [N-1:0][PW-1:0] prio_arr
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign live[g]     = req[g] & en[g];
        assign prio_arr[g] = prio_flat[g*PW +: PW];
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N  = 8,
    parameter int PW = arb_pkg::PRIO_W,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]         live,
    input  logic [N-1:0][PW-1:0] prio_arr,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [N-1:0]         onehot
);
    logic [PW-1:0] best_p;

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        best_p = '0;
        // strict greater-than keeps the lower index on a tie
        for (int i = 0; i < N; i++) begin
            if (live[i] && (!found || prio_arr[i] > best_p)) begin
                found  = 1'b1;
                idx    = IW'(i);
                best_p = prio_arr[i];
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/stream_prio_arbiter.sv
module stream_prio_arbiter #(
    parameter int N     = 8,
    parameter int PW    = arb_pkg::PRIO_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     enable_i,
    input  logic [N*PW-1:0]  prio_i,
    input  logic             done_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic             valid_o
);
    typedef struct packed {
        logic             busy;
        logic [N-1:0]     grant;
        logic [IDX_W-1:0] idx;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N-1:0]         live;
    logic [N-1:0][PW-1:0] prio_arr;
    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;
    logic [N-1:0]         win_onehot;

    arb_mask #(.N(N), .PW(PW)) u_mask (
        .req       (req_i),
        .en        (enable_i),
        .prio_flat (prio_i),
        .live      (live),
        .prio_arr  (prio_arr)
    );

    arb_pick #(.N(N), .PW(PW), .IW(IDX_W)) u_pick (
        .live     (live),
        .prio_arr (prio_arr),
        .found    (win_found),
        .idx      (win_idx),
        .onehot   (win_onehot)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (done_i) begin
                st_d.busy  = 1'b0;
                st_d.grant = '0;
                st_d.idx   = '0;
            end
        end else begin
            st_d.busy  = win_found;
            st_d.grant = win_onehot;
            st_d.idx   = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o     = st_q.grant;
    assign grant_idx_o = st_q.idx;
    assign valid_o     = st_q.busy;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_i,
    input logic [N-1:0]     enable_i,
    input logic             done_i,
    input logic [N-1:0]     grant_o,
    input logic [IDX_W-1:0] grant_idx_o,
    input logic             valid_o
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r8_valid_or: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (grant_o != '0));

    a_r8_index: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> grant_o[grant_idx_o]);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_i) |=> ($stable(grant_o) && $stable(grant_idx_o)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && done_i) |=> !valid_o);

    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && (req_i & enable_i) == '0) |=> !valid_o);

    a_r5_live_only: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (!valid_o || (($past(req_i & enable_i) & grant_o) != '0)));
endmodule

bind stream_prio_arbiter arb_checker #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .enable_i    (enable_i),
    .done_i      (done_i),
    .grant_o     (grant_o),
    .grant_idx_o (grant_idx_o),
    .valid_o     (valid_o)
);

// File: tb/stream_prio_arbiter_tb.sv
module stream_prio_arbiter_tb;
    localparam int N  = 8;
    localparam int PW = 2;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  en = '0;
    logic [N*PW-1:0] prio = '0;
    logic          done = 1'b0;
    logic [N-1:0]  grant;
    logic [IW-1:0] gidx;
    logic          valid;

    int compared = 0;
    int mismatched = 0;
    bit model_live = 0;
    string cur_tag = "R1";

    // model state
    bit m_busy = 0;
    int m_idx = 0;

    always #2.5 clk = ~clk;

    stream_prio_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .enable_i(en),
        .prio_i(prio), .done_i(done), .grant_o(grant),
        .grant_idx_o(gidx), .valid_o(valid)
    );

    always @(posedge clk) begin
        model_live = 1;
        if (!rst_n) begin
            m_busy = 0; m_idx = 0;
        end else if (m_busy) begin
            if (done) begin m_busy = 0; m_idx = 0; end
        end else begin
            bit hit;
            hit = 0;
            for (int lvl = 3; lvl >= 0 && !hit; lvl--)
                for (int s = 0; s < N && !hit; s++)
                    if (req[s] && en[s] && int'(prio[s*PW +: PW]) == lvl) begin
                        hit = 1; m_idx = s;
                    end
            m_busy = hit;
            if (!hit) m_idx = 0;
        end
    end

    task automatic compare(string tag);
        logic [N-1:0] eg;
        eg = m_busy ? (N'(1) << m_idx) : '0;
        compared++;
        if (grant !== eg || valid !== m_busy || int'(gidx) != m_idx) begin
            mismatched++;
            $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
                     tag, grant, gidx, valid, eg, m_idx, m_busy);
        end
        // R8: structural consistency of the outputs
        compared++;
        if ($countones(grant) > 1 || (valid && !grant[gidx]) || (valid != (grant != '0))) begin
            mismatched++;
            $display("FAIL R8: grant=%b idx=%0d valid=%b expected one-hot matching idx and valid",
                     grant, gidx, valid);
        end
    endtask

    task automatic step(logic [N-1:0] r, logic [N-1:0] e, logic [N*PW-1:0] p,
                        logic d, string tag);
        @(negedge clk);
        if (model_live) compare(cur_tag);
        req = r; en = e; prio = p; done = d; cur_tag = tag;
    endtask

    // grant one winner, hold it for a few cycles, then release
    task automatic serve(logic [N-1:0] r, logic [N-1:0] e, logic [N*PW-1:0] p, string tag);
        step(r, e, p, 1'b0, tag);
        step(r, e, p, 1'b0, tag);
        step(r, e, p, 1'b0, tag);
        step(r, e, p, 1'b1, tag);
        step('0, e, p, 1'b0, tag);
        step('0, e, p, 1'b0, tag);
    endtask

    initial begin
        // R1: reset
        rst_n = 1'b0;
        repeat (3) step('1, '1, '1, 1'b0, "R1");
        step('0, '0, '0, 1'b0, "R1");
        rst_n = 1'b1;
        step('0, '1, '0, 1'b0, "R1");
        // R2: nothing requesting, done while idle ignored
        step('0, '1, 16'hFFFF, 1'b0, "R2");
        step('0, '1, 16'hFFFF, 1'b1, "R2");
        step('0, '1, 16'hFFFF, 1'b1, "R2");
        // R5: disabled requests masked
        step('1, '0, 16'hFFFF, 1'b0, "R5");
        step(8'h0F, 8'hF0, 16'hFFFF, 1'b0, "R5");
        step(8'h0F, 8'hF0, 16'hFFFF, 1'b0, "R5");
        serve(8'hFF, 8'h80, 16'h0003, "R5");
        // R3: higher software priority beats lower index
        serve(8'h24, 8'hFF, 16'h0C10, "R3");
        serve(8'hFF, 8'hFF, 16'h0400, "R3");
        // R4: ties go to the lowest number
        serve(8'hFF, 8'hFF, 16'hAAAA, "R4");
        serve(8'hF0, 8'hFF, 16'hAAAA, "R4");
        serve(8'h81, 8'hFF, 16'hC003, "R4");
        // R9: field placement and level ordering
        serve(8'hFF, 8'hFF, 16'hC000, "R9");
        serve(8'hFF, 8'hFF, 16'h6559, "R9");
        // R6: grant held while requests change
        step(8'h08, 8'hFF, 16'h3040, 1'b0, "R6");
        step(8'h48, 8'hFF, 16'h3040, 1'b0, "R6");
        step(8'h40, 8'hFF, 16'h3040, 1'b0, "R6");
        step(8'h40, 8'h40, 16'hFFFF, 1'b0, "R6");
        step(8'h40, 8'h40, 16'hFFFF, 1'b0, "R6");
        // R7: release then re-arbitration to stream 6
        step(8'h40, 8'h40, 16'hFFFF, 1'b1, "R7");
        step(8'h40, 8'h40, 16'hFFFF, 1'b1, "R7");
        step(8'h40, 8'h40, 16'hFFFF, 1'b0, "R7");
        step(8'h40, 8'h40, 16'hFFFF, 1'b1, "R7");
        step('0, '1, 16'hFFFF, 1'b0, "R7");
        step('0, '1, 16'hFFFF, 1'b0, "R7");
        // R3: pseudo-random sweep
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2357;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                step(lf[7:0], lf[15:8] | 8'h11, {lf[23:16], lf[31:24]}, lf[3] & lf[9], "R3");
            end
        end
        step('0, '1, '0, 1'b1, "R3");
        step('0, '1, '0, 1'b0, "R3");
        step('0, '1, '0, 1'b0, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule